// File: doc/BRIEF.md
# DS2 Alarm Indication Signal Integrator

This block watches a received DS2 bit stream, one bit per cycle in which the bit enable is high. An external framer supplies a strobe that marks each multiframe boundary. In every multiframe the block counts received zeros. A multiframe with few enough zeros is judged to look like an unframed all-ones alarm signal.

Each such per-multiframe verdict drives a saturating up/down level counter. The alarm state flag rises when the level climbs to a programmable set threshold. It falls only when the level drops to a lower, programmable clear threshold, so the two thresholds give hysteresis.

The alarm state, a red-alarm (loss of frame) input and four further framer conditions are registered into a six-bit status word. When a status bit changes in either direction, the block latches a per-bit pending flag if that bit is enabled in the mask. The pending flags are cleared by a write-one-to-clear strobe, and any pending flag drives the interrupt line.

Top module: `ds2_ais_integrator`

## Requirements
- R1: A multiframe is judged alarm-like when it carried at most 4 zero bits, and not alarm-like when it carried 5 or more.
- R2: On each boundary strobe the level counter (`integ_level`) moves up by one for an alarm-like multiframe and down by one otherwise. The new value is visible no later than four cycles after the strobe.
- R3: The level counter holds at 0 when stepping down and holds at `integ_max` when stepping up.
- R4: `ais_state` becomes 1 in the same cycle that the level reaches or exceeds `set_thresh`.
- R5: `ais_state` becomes 0 when the level falls to or below `clr_thresh`. While the level lies strictly between the two thresholds, the flag keeps its previous value.
- R6: Status word layout, with 1 meaning the condition is active: bit 5 holds the alarm state, bit 4 holds the red alarm, and bits 3..0 hold `other_cond` with bit i equal to `other_cond[i]`. The word is registered one cycle after its sources.
- R7: A red alarm input held high through reset shows in status bit 4 on the first clock after reset is released.
- R8: A pending bit is set on a rising or a falling change of its status bit, but only when the matching `irq_mask` bit is 1. A masked change leaves the pending bit at 0. `irq` is high whenever any pending bit is set.
- R9: Pulsing `pend_clr_wr` for one cycle clears exactly the pending bits that are 1 in `pend_clr_bits`.
- R10: A bit presented while `bit_en` is low is not counted, even if it is a zero.
- R11: While reset is high, the level, alarm state, status word, pending bits and `irq` are all 0.
- R12: Each boundary strobe restarts the zero tally, so zeros from one multiframe do not count toward the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Received DS2 data bit |
| mf_strobe | input | 1 | Multiframe boundary pulse from the framer |
| red_alarm_in | input | 1 | Loss-of-frame condition from the framer |
| other_cond | input | 4 | Further framer conditions placed in status bits 3..0 |
| set_thresh | input | 6 | Level at or above which the alarm is declared |
| clr_thresh | input | 6 | Level at or below which the alarm is withdrawn |
| integ_max | input | 6 | Saturation ceiling of the level counter |
| irq_mask | input | 6 | Per-status-bit interrupt enable |
| pend_clr_wr | input | 1 | Write strobe for clearing pending bits |
| pend_clr_bits | input | 6 | Pending bits to clear when the strobe is high |
| integ_level | output | 6 | Current integration level |
| ais_state | output | 1 | Integrated alarm state |
| status_word | output | 6 | Registered status word |
| irq_pend | output | 6 | Latched pending flags |
| irq | output | 1 | OR of the pending flags |

## Verification
The hardest state to reach is the flag held on inside the hysteresis band with the level at its ceiling and then walked down one step at a time. Getting there takes a long run of alarm-like multiframes followed by single degraded ones, each 1176 bits long. The stimulus table lays out that path frame by frame, including frames with exactly 4 and exactly 5 zeros. Separate directed frames drive every bit as zero but raise the enable for only three of them, which shows that unqualified bits are ignored.

// File: rtl/ds2_alarm_pkg.sv
package ds2_alarm_pkg;
  localparam int STAT_W    = 6;
  localparam int AIS_BIT   = 5;
  localparam int RED_BIT   = 4;
  localparam int OTHER_W   = 4;
  typedef logic [STAT_W-1:0] stat_vec_t;
endpackage

// File: rtl/ds2_mf_zero_tally.sv
module ds2_mf_zero_tally #(
  parameter int ZERO_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic mf_strobe,
  output logic mf_done,
  output logic mf_alarm_like
);
  localparam int ZW = $clog2(ZERO_LIMIT + 1);
  localparam logic [ZW-1:0] ZSAT = ZW'(ZERO_LIMIT);

  logic [ZW-1:0] zcnt;
  logic          zero_seen;

  assign zero_seen = bit_en & ~rx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt          <= '0;
      mf_done       <= 1'b0;
      mf_alarm_like <= 1'b0;
    end else begin
      mf_done <= mf_strobe;
      if (mf_strobe) begin
        // decision uses the tally of the multiframe just closed
        mf_alarm_like <= (zcnt < ZSAT);
        zcnt          <= zero_seen ? ZW'(1) : '0;
      end else if (zero_seen && zcnt != ZSAT) begin
        zcnt <= zcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ds2_level_integ.sv
module ds2_level_integ #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             step_up,
  input  logic [LVL_W-1:0] set_th,
  input  logic [LVL_W-1:0] clr_th,
  input  logic [LVL_W-1:0] lvl_max,
  output logic [LVL_W-1:0] level,
  output logic             alarm
);
  logic [LVL_W-1:0] level_nx;
  logic             alarm_nx;

  always_comb begin
    level_nx = level;
    if (step_en) begin
      if (step_up) level_nx = (level >= lvl_max) ? lvl_max : level + 1'b1;
      else         level_nx = (level == '0) ? '0 : level - 1'b1;
    end
  end

  always_comb begin
    alarm_nx = alarm;
    if (step_en) begin
      if (level_nx >= set_th)      alarm_nx = 1'b1;
      else if (level_nx <= clr_th) alarm_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      alarm <= 1'b0;
    end else begin
      level <= level_nx;
      alarm <= alarm_nx;
    end
  end
endmodule

// File: rtl/ds2_stat_irq.sv
module ds2_stat_irq
  import ds2_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  stat_vec_t stat_in,
  input  stat_vec_t mask,
  input  logic      clr_wr,
  input  stat_vec_t clr_bits,
  output stat_vec_t stat,
  output stat_vec_t pend,
  output logic      irq
);
  stat_vec_t edges;
  stat_vec_t clr_v;

  assign edges = (stat_in ^ stat) & mask;
  assign clr_v = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_in;
      pend <= (pend & ~clr_v) | edges;
      irq  <= |((pend & ~clr_v) | edges);
    end
  end
endmodule

// File: rtl/ds2_ais_integrator.sv
module ds2_ais_integrator
  import ds2_alarm_pkg::*;
#(
  parameter int ZERO_LIMIT = 5,
  parameter int LVL_W      = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               rx_bit,
  input  logic               mf_strobe,
  input  logic               red_alarm_in,
  input  logic [OTHER_W-1:0] other_cond,
  input  logic [LVL_W-1:0]   set_thresh,
  input  logic [LVL_W-1:0]   clr_thresh,
  input  logic [LVL_W-1:0]   integ_max,
  input  logic [STAT_W-1:0]  irq_mask,
  input  logic               pend_clr_wr,
  input  logic [STAT_W-1:0]  pend_clr_bits,
  output logic [LVL_W-1:0]   integ_level,
  output logic               ais_state,
  output logic [STAT_W-1:0]  status_word,
  output logic [STAT_W-1:0]  irq_pend,
  output logic               irq
);
  logic      mf_done;
  logic      mf_alarm_like;
  stat_vec_t stat_src;

  ds2_mf_zero_tally #(.ZERO_LIMIT(ZERO_LIMIT)) u_tally (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .mf_strobe(mf_strobe), .mf_done(mf_done), .mf_alarm_like(mf_alarm_like)
  );

  ds2_level_integ #(.LVL_W(LVL_W)) u_integ (
    .clk(clk), .rst(rst), .step_en(mf_done), .step_up(mf_alarm_like),
    .set_th(set_thresh), .clr_th(clr_thresh), .lvl_max(integ_max),
    .level(integ_level), .alarm(ais_state)
  );

  always_comb begin
    stat_src              = '0;
    stat_src[AIS_BIT]     = ais_state;
    stat_src[RED_BIT]     = red_alarm_in;
    stat_src[OTHER_W-1:0] = other_cond;
  end

  ds2_stat_irq u_stat (
    .clk(clk), .rst(rst), .stat_in(stat_src), .mask(irq_mask),
    .clr_wr(pend_clr_wr), .clr_bits(pend_clr_bits),
    .stat(status_word), .pend(irq_pend), .irq(irq)
  );
endmodule

// File: rtl/ds2_ais_chk.sv
module ds2_ais_chk
  import ds2_alarm_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  integ_level,
  input logic [LVL_W-1:0]  set_thresh,
  input logic [LVL_W-1:0]  clr_thresh,
  input logic              ais_state,
  input logic [STAT_W-1:0] status_word,
  input logic [STAT_W-1:0] irq_pend,
  input logic              pend_clr_wr
);
  // R2: the level moves by at most one per cycle
  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (integ_level == $past(integ_level)) || (integ_level == $past(integ_level) + 1'b1)
    || (integ_level + 1'b1 == $past(integ_level)));

  // R4: at or above the set threshold the alarm is on
  assert_set_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ($stable(set_thresh) && set_thresh != '0 && integ_level >= set_thresh) |-> ais_state);

  // R5: at or below the clear threshold the alarm is off
  assert_clr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($stable(clr_thresh) && integ_level <= clr_thresh && clr_thresh < set_thresh) |-> !ais_state);

  // R6: status bit 5 follows the alarm flag one cycle later
  assert_stat_ais_R6: assert property (@(posedge clk) disable iff (rst)
    status_word[AIS_BIT] == $past(ais_state));

  // R8: a pending bit only rises when its status bit changed
  assert_pend_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ((irq_pend & ~$past(irq_pend)) & ~(status_word ^ $past(status_word))) == '0);

  // R9: without a clear strobe, pending bits never drop
  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(pend_clr_wr) |-> ((~irq_pend & $past(irq_pend)) == '0));
endmodule

bind ds2_ais_integrator ds2_ais_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .integ_level(integ_level), .set_thresh(set_thresh),
  .clr_thresh(clr_thresh), .ais_state(ais_state), .status_word(status_word),
  .irq_pend(irq_pend), .pend_clr_wr(pend_clr_wr)
);

// File: tb/sim_ds2_ais_integrator.sv
module sim_ds2_ais_integrator;
  localparam int MF_BITS = 1176;
  localparam int NV = 15;
  // zeros per multiframe, expected level, expected alarm (set=3 clr=1 max=5)
  localparam int VZ[NV] = '{0, 4, 5, 0, 0, 0, 0, 0, 9, 5, 100, 6, 7, 7, 2};
  localparam int VL[NV] = '{1, 2, 1, 2, 3, 4, 5, 5, 4, 3, 2,   1, 0, 0, 1};
  localparam int VA[NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1,   0, 0, 0, 0};

  logic clk = 0, rst = 1;
  logic bit_en = 0, rx_bit = 1, mf_strobe = 0, red_alarm_in = 1;
  logic [3:0] other_cond = 0;
  logic [5:0] set_thresh = 6'd3, clr_thresh = 6'd1, integ_max = 6'd5;
  logic [5:0] irq_mask = 6'b110000, pend_clr_bits = 0;
  logic pend_clr_wr = 0;
  logic [5:0] integ_level, status_word, irq_pend;
  logic ais_state, irq;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  ds2_ais_integrator u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .mf_strobe(mf_strobe),
    .red_alarm_in(red_alarm_in), .other_cond(other_cond), .set_thresh(set_thresh),
    .clr_thresh(clr_thresh), .integ_max(integ_max), .irq_mask(irq_mask),
    .pend_clr_wr(pend_clr_wr), .pend_clr_bits(pend_clr_bits),
    .integ_level(integ_level), .ais_state(ais_state), .status_word(status_word),
    .irq_pend(irq_pend), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_mf(input int nz, input bit sparse);
    for (int i = 0; i < MF_BITS; i++) begin
      @(negedge clk);
      if (sparse) begin bit_en = (i < 3); rx_bit = 0; end
      else begin bit_en = 1; rx_bit = (i < nz) ? 1'b0 : 1'b1; end
    end
    @(negedge clk); bit_en = 0; rx_bit = 1; mf_strobe = 1;
    @(negedge clk); mf_strobe = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_pend(input logic [5:0] b);
    @(negedge clk); pend_clr_wr = 1; pend_clr_bits = b;
    @(negedge clk); pend_clr_wr = 0; pend_clr_bits = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 level", integ_level, 0);
    chk("R11 ais", ais_state, 0);
    chk("R11 status", status_word, 0);
    chk("R11 pend", irq_pend, 0);
    chk("R11 irq", irq, 0);
    rst = 0;
    @(negedge clk);
    // R7: red alarm visible one clock after release
    chk("R7 red bit", status_word, 6'b010000);
    chk("R8 pend red rise", irq_pend, 6'b010000);
    chk("R8 irq", irq, 1);
    clear_pend(6'b010000);
    chk("R9 cleared", irq_pend, 0);
    chk("R9 irq low", irq, 0);
    red_alarm_in = 0;
    repeat (2) @(negedge clk);
    chk("R8 pend red fall", irq_pend, 6'b010000);
    clear_pend(6'b111111);
    chk("R9 cleared all", irq_pend, 0);

    // R1 R2 R3 R4 R5 R12: table walk
    for (int v = 0; v < NV; v++) begin
      send_mf(VZ[v], 1'b0);
      chk($sformatf("R2/R3 level v%0d", v), integ_level, VL[v]);
      chk($sformatf("R4/R5 ais v%0d", v), ais_state, VA[v]);
      chk($sformatf("R6 stat bit5 v%0d", v), status_word[5], VA[v]);
    end
    // R8: alarm rose and fell while unmasked -> pending bit5
    chk("R8 pend ais", irq_pend, 6'b100000);
    clear_pend(6'b100000);

    // R10: all bits zero but enable only on three of them -> alarm-like
    send_mf(0, 1'b1);
    chk("R10 sparse up", integ_level, 2);
    send_mf(0, 1'b1);
    chk("R10 sparse up again", integ_level, 3);
    chk("R4 set again", ais_state, 1);

    // R6 / R8: other conditions, masked then unmasked
    irq_mask = 6'b000000;
    clear_pend(6'b111111);
    other_cond = 4'b1010;
    repeat (3) @(negedge clk);
    chk("R6 other bits", status_word, 6'b101010);
    chk("R8 masked no pend", irq_pend, 0);
    irq_mask = 6'b000001;
    other_cond = 4'b1011;
    repeat (2) @(negedge clk);
    chk("R8 unmasked bit0", irq_pend, 6'b000001);
    chk("R8 irq bit0", irq, 1);
    clear_pend(6'b000010);
    chk("R9 selective clear keeps", irq_pend, 6'b000001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule